// File: doc/BRIEF.md
# Serial Flash Program/Erase Sequencer

This block sits on the host side of a four-wire serial peripheral bus and drives an external NOR flash device through its modify operations. A local client asks for one of three jobs: program a run of bytes taken from a small client-owned buffer, erase the sector containing an address, or erase the whole device. The sequencer builds every bus transaction itself. Each one is a chip-select window carrying whole bytes.

Before any modifying command, the sequencer sends a one-byte write-enable transaction of its own. It then sends the command. After that it keeps reading the device status byte until the busy flag drops, and only then does it report completion. It never waits for a fixed worst-case time.

A program request may run across one or more 256-byte page boundaries. The sequencer cuts such a request into page-bounded rounds, and each round repeats the enable, program and poll steps with the address moved forward. The buffer is read combinationally: the sequencer presents an index and takes the byte back in the same cycle.

Top module: `flash_pe_seq`

## Requirements
- R1: The bus runs in mode 0. The serial clock stays low whenever chip select is high. Bytes are sent most significant bit first, with each bit changed after a falling clock edge and sampled on a rising edge. No chip-select window ends partway through a byte.
- R2: Every modifying command (program, sector erase, device erase) follows its own separate chip-select window that carries only the byte 06h.
- R3: A program window carries the byte 02h, then three address bytes (most significant first), then the data bytes. Data byte i of a round is the buffer entry at index (bytes already programmed by earlier rounds + i), read from `buf_data_i` in the same cycle that `buf_idx_o` shows that index.
- R4: A program request is split into rounds. Each round moves min(remaining, 256 - address[7:0]) bytes. The next round starts at the address just past the previous round. The rounds together carry exactly the requested length.
- R5: Request code 1 sends D8h followed by the three address bytes. Request code 2 sends C7h alone. Request code 0 is a program.
- R6: After each modifying window, the block issues status reads. Each read is a window holding 05h followed by one byte read back. Bit 0 of the read byte set to 1 means the device is busy, and another read follows. The operation or round continues only after a read with bit 0 equal to 0.
- R7: Chip select stays high for at least `cs_gap_i` + 1 clock cycles before every window of an operation.
- R8: `busy_o` rises in the cycle after a request is accepted and stays high until completion. `done_o` is a one-cycle pulse, asserted in the same cycle that `busy_o` falls.
- R9: A request presented while `busy_o` is high is ignored. It does not change the running operation, and it produces no later bus activity.
- R10: Request code 3 is ignored: no bus activity and no `done_o`.
- R11: A program request with length 0 produces a `done_o` pulse in the cycle after acceptance, with no bus activity and no `busy_o`.
- R12: After reset, chip select is high, the serial clock is low, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, sampled while idle |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 device erase, 3 none |
| req_addr_i | input | 24 | Start address (program) or sector address |
| req_len_i | input | 10 | Program length in bytes, 0 to BUF_DEPTH |
| cs_gap_i | input | 4 | Extra high cycles of chip select between windows |
| buf_idx_o | output | 9 | Index into the client data buffer |
| buf_data_i | input | 8 | Buffer byte at `buf_idx_o`, same cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |

## Verification
Two functions can meet in a single cycle. A fresh request can arrive while an operation is running, and the last status byte of a round decides between starting another round and finishing. The bench provokes the first by strobing a device-erase request in the middle of a long split program. It provokes the second with a device model that keeps the busy flag set for a random number of reads after each modifying window. The verdict comes from the transactions decoded on the bus: the sequence of windows, their addresses and payloads, the final status read and the count of completion pulses.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   localparam int unsigned BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OPC_WR_ENABLE  = 8'h06;
   localparam logic [BYTE_W-1:0] OPC_PAGE_WR    = 8'h02;
   localparam logic [BYTE_W-1:0] OPC_SECT_ERASE = 8'hD8;
   localparam logic [BYTE_W-1:0] OPC_CHIP_ERASE = 8'hC7;
   localparam logic [BYTE_W-1:0] OPC_STAT_RD    = 8'h05;

   typedef enum logic [1:0] {
      REQ_PROG = 2'd0,
      REQ_SECT = 2'd1,
      REQ_BULK = 2'd2,
      REQ_NONE = 2'd3
   } req_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GAP  = 2'd1,
      ST_XFER = 2'd2
   } seq_st_e;

   typedef enum logic [1:0] {
      TX_WEN  = 2'd0,
      TX_MOD  = 2'd1,
      TX_POLL = 2'd2
   } txn_e;
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
   import flash_seq_pkg::*;
#(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] tx_i,
   output logic              done_o,
   output logic [BYTE_W-1:0] rx_o,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i
);
   localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int unsigned BIT_W = $clog2(BYTE_W);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   logic              active_q;
   logic              tick;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] rx_q;
   logic [BIT_W-1:0]  bit_q;
   logic              sck_q;
   logic              done_q;

   if (HALF_DIV == 1) begin : g_nodiv
      assign tick = active_q;
   end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (!active_q || div_q == DIV_W'(HALF_DIV - 1)) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
      assign tick = active_q && (div_q == DIV_W'(HALF_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sh_q     <= '0;
         rx_q     <= '0;
         bit_q    <= '0;
         sck_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !active_q) begin
            active_q <= 1'b1;
            sh_q     <= tx_i;
            bit_q    <= '0;
            sck_q    <= 1'b0;
         end else if (tick) begin
            if (!sck_q) begin
               sck_q <= 1'b1;
               rx_q  <= {rx_q[BYTE_W-2:0], miso_i};
            end else begin
               sck_q <= 1'b0;
               if (bit_q == BIT_W'(BYTE_W - 1)) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign done_o = done_q;
   assign rx_o   = rx_q;
   assign sck_o  = sck_q;
   assign mosi_o = sh_q[BYTE_W-1];

   AST_NO_RESTART : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !active_q); // R1
   AST_SCK_REST : assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !sck_q); // R1
endmodule

// File: rtl/page_split.sv
module page_split #(
   parameter int unsigned PAGE_BYTES = 256,
   parameter int unsigned LEN_W      = 10
) (
   input  logic [$clog2(PAGE_BYTES)-1:0] addr_lo_i,
   input  logic [LEN_W-1:0]              rem_i,
   output logic [LEN_W-1:0]              chunk_o
);
   localparam int unsigned PG_W = $clog2(PAGE_BYTES);

   if ((1 << PG_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (LEN_W < PG_W + 1) begin : g_bad_len
      $error("LEN_W too narrow to hold one page");
   end

   logic [LEN_W-1:0] room;

   always_comb begin
      room    = LEN_W'(PAGE_BYTES) - LEN_W'(addr_lo_i);
      chunk_o = (rem_i < room) ? rem_i : room;
   end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
   import flash_seq_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 3,
   parameter int unsigned PAGE_BYTES = 256,
   parameter int unsigned BUF_DEPTH  = 512,
   parameter int unsigned GAP_W      = 4,
   parameter int unsigned HALF_DIV   = 2,
   parameter int unsigned BUSY_BIT   = 0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid_i,
   input  logic [1:0]                       req_op_i,
   input  logic [8*ADDR_BYTES-1:0]          req_addr_i,
   input  logic [$clog2(BUF_DEPTH+1)-1:0]   req_len_i,
   input  logic [GAP_W-1:0]                 cs_gap_i,
   output logic [$clog2(BUF_DEPTH)-1:0]     buf_idx_o,
   input  logic [7:0]                       buf_data_i,
   output logic                             busy_o,
   output logic                             done_o,
   output logic                             spi_cs_n_o,
   output logic                             spi_sck_o,
   output logic                             spi_mosi_o,
   input  logic                             spi_miso_i
);
   localparam int unsigned ADDR_W = 8 * ADDR_BYTES;
   localparam int unsigned PG_W   = $clog2(PAGE_BYTES);
   localparam int unsigned LEN_W  = $clog2(BUF_DEPTH + 1);
   localparam int unsigned IDX_W  = $clog2(BUF_DEPTH);
   localparam int unsigned HDR    = 1 + ADDR_BYTES;
   localparam int unsigned BI_W   = $clog2(HDR + PAGE_BYTES);

   if (BUF_DEPTH < PAGE_BYTES) begin : g_bad_buf
      $error("BUF_DEPTH must cover at least one page");
   end
   if (ADDR_BYTES < 2 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("ADDR_BYTES must be 2 to 4");
   end
   if (BUSY_BIT >= BYTE_W) begin : g_bad_bit
      $error("BUSY_BIT outside the status byte");
   end

   seq_st_e              st_q;
   txn_e                 txn_q;
   req_op_e              op_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [LEN_W-1:0]     rem_q;
   logic [LEN_W-1:0]     off_q;
   logic [BI_W-1:0]      byte_idx_q;
   logic [GAP_W-1:0]     gap_q;
   logic                 cs_q;
   logic                 done_q;
   logic                 start_q;
   logic [BYTE_W-1:0]    tx_byte;
   logic [BYTE_W-1:0]    rx_byte;
   logic                 byte_done;
   logic [LEN_W-1:0]     chunk;
   logic [BI_W-1:0]      last_idx;
   logic [LEN_W-1:0]     data_pos;
   logic [BYTE_W-1:0]    mod_opc;

   page_split #(
      .PAGE_BYTES (PAGE_BYTES),
      .LEN_W      (LEN_W)
   ) u_split (
      .addr_lo_i (addr_q[PG_W-1:0]),
      .rem_i     (rem_q),
      .chunk_o   (chunk)
   );

   spi_byte_engine #(
      .HALF_DIV (HALF_DIV)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_q),
      .tx_i    (tx_byte),
      .done_o  (byte_done),
      .rx_o    (rx_byte),
      .sck_o   (spi_sck_o),
      .mosi_o  (spi_mosi_o),
      .miso_i  (spi_miso_i)
   );

   always_comb begin
      unique case (op_q)
         REQ_SECT: mod_opc = OPC_SECT_ERASE;
         REQ_BULK: mod_opc = OPC_CHIP_ERASE;
         default:  mod_opc = OPC_PAGE_WR;
      endcase
   end

   always_comb begin
      unique case (txn_q)
         TX_WEN:  last_idx = '0;
         TX_POLL: last_idx = BI_W'(1);
         default: begin
            if (op_q == REQ_BULK)      last_idx = '0;
            else if (op_q == REQ_SECT) last_idx = BI_W'(HDR - 1);
            else                       last_idx = BI_W'(HDR - 1) + BI_W'(chunk);
         end
      endcase
   end

   assign data_pos  = off_q + LEN_W'(byte_idx_q) - LEN_W'(HDR);
   assign buf_idx_o = data_pos[IDX_W-1:0];

   always_comb begin
      tx_byte = '0;
      unique case (txn_q)
         TX_WEN:  tx_byte = OPC_WR_ENABLE;
         TX_POLL: tx_byte = (byte_idx_q == '0) ? OPC_STAT_RD : '0;
         default: begin
            if (byte_idx_q == '0) begin
               tx_byte = mod_opc;
            end else if (byte_idx_q < BI_W'(HDR)) begin
               for (int k = 0; k < ADDR_BYTES; k++) begin
                  if (byte_idx_q == BI_W'(k + 1)) tx_byte = addr_q[8*(ADDR_BYTES-1-k) +: 8];
               end
            end else begin
               tx_byte = buf_data_i;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         txn_q      <= TX_WEN;
         op_q       <= REQ_PROG;
         addr_q     <= '0;
         rem_q      <= '0;
         off_q      <= '0;
         byte_idx_q <= '0;
         gap_q      <= '0;
         cs_q       <= 1'b1;
         done_q     <= 1'b0;
         start_q    <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         start_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid_i && req_op_i != REQ_NONE) begin
                  if (req_op_i == REQ_PROG && req_len_i == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     op_q   <= req_op_e'(req_op_i);
                     addr_q <= req_addr_i;
                     rem_q  <= req_len_i;
                     off_q  <= '0;
                     txn_q  <= TX_WEN;
                     gap_q  <= '0;
                     st_q   <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               if (gap_q >= cs_gap_i) begin
                  cs_q       <= 1'b0;
                  start_q    <= 1'b1;
                  byte_idx_q <= '0;
                  st_q       <= ST_XFER;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            ST_XFER: begin
               if (byte_done) begin
                  if (byte_idx_q != last_idx) begin
                     byte_idx_q <= byte_idx_q + 1'b1;
                     start_q    <= 1'b1;
                  end else begin
                     cs_q  <= 1'b1;
                     gap_q <= '0;
                     st_q  <= ST_GAP;
                     unique case (txn_q)
                        TX_WEN: txn_q <= TX_MOD;
                        TX_MOD: begin
                           txn_q <= TX_POLL;
                           if (op_q == REQ_PROG) begin
                              addr_q <= addr_q + ADDR_W'(chunk);
                              rem_q  <= rem_q - chunk;
                              off_q  <= off_q + chunk;
                           end
                        end
                        default: begin
                           if (rx_byte[BUSY_BIT]) begin
                              txn_q <= TX_POLL;
                           end else if (op_q == REQ_PROG && rem_q != '0) begin
                              txn_q <= TX_WEN;
                           end else begin
                              st_q   <= ST_IDLE;
                              done_q <= 1'b1;
                           end
                        end
                     endcase
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = done_q;
   assign spi_cs_n_o = cs_q;

   AST_CS_IDLE_HIGH : assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> spi_cs_n_o); // R12
   AST_SCK_LOW_UNSEL : assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n_o |-> !spi_sck_o); // R1
   AST_DONE_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_DONE_NOT_BUSY : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R8
   AST_HOLD_REQ : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && req_valid_i) |=> ($stable(op_q) && busy_o)); // R9
   AST_DATA_IN_PAGE : assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && txn_q == TX_MOD && op_q == REQ_PROG && byte_idx_q >= BI_W'(HDR))
      |-> ((32'(addr_q[PG_W-1:0]) + 32'(byte_idx_q) - HDR) < PAGE_BYTES)); // R4
endmodule

// File: tb/flash_pe_seq_tb.sv
module flash_pe_seq_tb_top;
   localparam int BUF_DEPTH = 512;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [1:0]  req_op;
   logic [23:0] req_addr;
   logic [9:0]  req_len;
   logic [3:0]  cs_gap;
   logic [8:0]  buf_idx;
   logic [7:0]  buf_data;
   logic        busy, done;
   logic        spi_cs_n, spi_sck, spi_mosi;
   logic        spi_miso = 1'b0;

   logic [7:0]  bufm [BUF_DEPTH];
   assign buf_data = bufm[buf_idx];

   always #5 clk = ~clk;

   flash_pe_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
      .req_addr_i(req_addr), .req_len_i(req_len), .cs_gap_i(cs_gap),
      .buf_idx_o(buf_idx), .buf_data_i(buf_data), .busy_o(busy), .done_o(done),
      .spi_cs_n_o(spi_cs_n), .spi_sck_o(spi_sck), .spi_mosi_o(spi_mosi),
      .spi_miso_i(spi_miso)
   );

   int errors = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   int          nb = 0;
   int          bitn = 0;
   logic [7:0]  cur = '0;
   logic [7:0]  tb_bytes [300];
   int          dev_busy = 0;
   bit          last_busy = 1'b0;
   int          log_cnt = 0;
   logic [7:0]  log_op [64];
   int          log_n [64];
   logic [23:0] log_addr [64];
   int          log_dstart [64];
   logic [7:0]  dlog [2048];
   int          dcnt = 0;
   int          partial = 0;
   int          sck_viol = 0;
   int          done_cnt = 0;
   int          hi = 0;
   int          gmin = 1000000;

   always @(negedge spi_cs_n) begin
      nb = 0;
      bitn = 0;
   end

   always @(posedge spi_sck) if (!spi_cs_n) begin
      cur = {cur[6:0], spi_mosi};
      bitn++;
      if (bitn == 8) begin
         if (nb < 300) tb_bytes[nb] = cur;
         nb++;
         bitn = 0;
      end
   end

   always @(negedge spi_sck) if (!spi_cs_n && nb >= 1 && tb_bytes[0] == 8'h05) begin
      logic [7:0] st;
      st = {7'd0, (dev_busy > 0)};
      spi_miso = st[7 - bitn];
   end

   always @(posedge spi_cs_n) begin
      if (bitn != 0) partial++;
      if (nb > 0 && log_cnt < 64) begin
         log_op[log_cnt]     = tb_bytes[0];
         log_n[log_cnt]      = nb;
         log_addr[log_cnt]   = (nb >= 4) ? {tb_bytes[1], tb_bytes[2], tb_bytes[3]} : 24'd0;
         log_dstart[log_cnt] = dcnt;
         for (int i = 4; i < nb && i < 300; i++) begin
            if (dcnt < 2048) dlog[dcnt] = tb_bytes[i];
            dcnt++;
         end
         if (tb_bytes[0] == 8'h02 || tb_bytes[0] == 8'hD8 || tb_bytes[0] == 8'hC7)
            dev_busy = $urandom_range(3, 0);
         if (tb_bytes[0] == 8'h05) begin
            last_busy = (dev_busy > 0);
            if (dev_busy > 0) dev_busy--;
         end
         log_cnt++;
      end
      nb = 0;
      bitn = 0;
   end

   always @(negedge clk) begin
      if (spi_cs_n && spi_sck) sck_viol++;
      if (done) done_cnt++;
      if (!spi_cs_n) begin
         if (hi > 0 && hi < gmin) gmin = hi;
         hi = 0;
      end else if (busy) hi++;
      else hi = 0;
   end

   // ---------------- expected-value helpers ----------------
   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic check_op(input int op, input logic [23:0] addr, input int len);
      int fl [64];
      int fn = 0;
      int exp_n;
      int a, rem, off, ch, r, bad, i0, i1, nopoll;
      for (int k = 0; k < log_cnt; k++)
         if (log_op[k] != 8'h05) begin fl[fn] = k; fn++; end
      if (op == 0) begin
         a = int'(addr); rem = len; off = 0; r = 0;
         while (rem > 0) begin
            ch = min2(rem, 256 - (a % 256));
            if (2*r + 1 >= fn) begin
               chk(1'b0, "R4 round missing", fn, 2*r + 2);
               break;
            end
            i0 = fl[2*r]; i1 = fl[2*r+1];
            chk(log_op[i0] == 8'h06 && log_n[i0] == 1, "R2 enable window", log_op[i0], 6);
            chk(log_op[i1] == 8'h02 && log_n[i1] == 4 + ch, "R4 program length", log_n[i1], 4 + ch);
            chk(log_addr[i1] == a[23:0], "R4 round address", log_addr[i1], a);
            bad = 0;
            for (int i = 0; i < ch; i++)
               if (dlog[log_dstart[i1] + i] != bufm[off + i]) bad++;
            chk(bad == 0, "R3 data bytes", bad, 0);
            a = (a + ch) % (1 << 24); rem -= ch; off += ch; r++;
         end
         exp_n = 2 * r;
      end else begin
         exp_n = 2;
         if (fn >= 2) begin
            chk(log_op[fl[0]] == 8'h06 && log_n[fl[0]] == 1, "R2 enable window", log_op[fl[0]], 6);
            if (op == 1) begin
               chk(log_op[fl[1]] == 8'hD8 && log_n[fl[1]] == 4, "R5 sector opcode", log_op[fl[1]], 8'hD8);
               chk(log_addr[fl[1]] == addr, "R5 sector address", log_addr[fl[1]], addr);
            end else begin
               chk(log_op[fl[1]] == 8'hC7 && log_n[fl[1]] == 1, "R5 device erase", log_op[fl[1]], 8'hC7);
            end
         end
      end
      chk(fn == exp_n, "R4 window count", fn, exp_n);
      nopoll = 0;
      for (int k = 0; k < fn; k++)
         if (log_op[fl[k]] != 8'h06 && (fl[k] + 1 >= log_cnt || log_op[fl[k] + 1] != 8'h05)) nopoll++;
      chk(nopoll == 0, "R6 poll after modify", nopoll, 0);
      chk(log_cnt > 0 && log_op[log_cnt-1] == 8'h05 && !last_busy && dev_busy == 0,
          "R6 ends on idle status", dev_busy, 0);
      chk(partial == 0 && sck_viol == 0, "R1 framing", partial + sck_viol, 0);
      chk(gmin >= int'(cs_gap) + 1, "R7 deselect gap", gmin, int'(cs_gap) + 1);
   endtask

   task automatic run_op(input int op, input logic [23:0] addr, input int len, input bit inject);
      int cyc;
      int saved;
      log_cnt = 0; dcnt = 0; gmin = 1000000; done_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op[1:0]; req_addr = addr; req_len = len[9:0];
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R8 busy after accept", busy, 1);
      cyc = 0;
      while (!done && cyc < 60000) begin
         @(negedge clk);
         cyc++;
         req_valid = inject && (cyc == 20);
         if (inject) begin req_op = 2'd2; req_addr = 24'h0; end
      end
      req_valid = 1'b0;
      chk(done && !busy, "R8 done with busy low", {done, busy}, 2);
      @(negedge clk);
      chk(!done, "R8 done single cycle", done, 0);
      check_op(op, addr, len);
      if (inject) begin
         saved = log_cnt;
         repeat (40) @(negedge clk);
         chk(!busy && log_cnt == saved && done_cnt == 1, "R9 busy request ignored", log_cnt - saved + done_cnt, 1);
      end
   endtask

   // ---------------- main sequence ----------------
   initial begin
      int seed_v;
      int rop, rlen;
      seed_v = $urandom(32'd5150);
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len = '0; cs_gap = 4'd3;
      for (int i = 0; i < BUF_DEPTH; i++) bufm[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      chk(spi_cs_n && !spi_sck && !busy && !done, "R12 reset state",
          {spi_cs_n, spi_sck, busy, done}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(0, 24'h0000FE, 5, 1'b0);      // two rounds: 2 + 3 bytes
      cs_gap = 4'd0;
      run_op(0, 24'h001200, 256, 1'b0);    // aligned full page
      cs_gap = 4'd9;
      run_op(0, 24'h000380, 512, 1'b1);    // three rounds, request during busy
      run_op(1, 24'h0A5123, 0, 1'b0);
      run_op(2, 24'h000000, 0, 1'b0);

      // R10: code 3 does nothing
      log_cnt = 0; done_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd3; req_addr = 24'h123456; req_len = 10'd9;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (30) @(negedge clk);
      chk(!busy && log_cnt == 0 && done_cnt == 0, "R10 code 3 ignored", log_cnt + done_cnt, 0);

      // R11: zero-length program
      log_cnt = 0; done_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_addr = 24'h000010; req_len = 10'd0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(done && !busy, "R11 zero length done", {done, busy}, 2);
      repeat (20) @(negedge clk);
      chk(log_cnt == 0 && done_cnt == 1 && !busy, "R11 no bus activity", log_cnt, 0);

      for (int n = 0; n < 6; n++) begin
         rop  = int'($urandom % 3);
         rlen = 1 + int'($urandom % 300);
         cs_gap = 4'($urandom);
         run_op(rop, 24'($urandom), rlen, 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1900000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule